// File: doc/BRIEF.md
# Layer Compositor with Palette Lookup

This block is the last stage of a tile-based 2D video pipeline. On every pixel clock it takes one candidate pixel from the background layer and one candidate from each of a fixed number of foreground sprite units. Each candidate carries a valid flag, a 3-bit palette select and a 3-bit colour index. The block picks the winning candidate and translates it through a writable 64-entry palette memory into a 12-bit RGB colour. It then drives that colour onto the video output.

Sprites always cover the background. Among the sprites, the lowest-numbered one showing an opaque pixel wins. Colour index 0 on a sprite means "see through". A host-side port reads and writes the palette memory at any time, including during active display.

Top module: `layer_compositor`

## Requirements
- R1: The palette entry used for a candidate is at address pal*8 + idx: palette select in address bits 5:3 and colour index in bits 2:0. Each entry is 12 bits, with red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R2: A host write (host_we=1) stores host_wdata at host_addr on the clock edge. host_rdata presents the entry at host_addr registered one clock edge after the address is sampled.
- R3: A sprite candidate whose valid bit is 0, or whose colour index is 0, never contributes the output colour.
- R4: When several sprite candidates are opaque, the one with the lowest sprite number wins.
- R5: When no sprite is opaque and the background candidate is valid, the background entry is shown, including when the background colour index is 0.
- R6: When no sprite is opaque and the background candidate is not valid, rgb is 0.
- R7: A pixel presented with pix_active=0 produces rgb=0.
- R8: rgb reflects the candidates presented two clock edges earlier: one address-set cycle, then one memory-read cycle.
- R9: When a host write hits the entry being read for a pixel lookup on the same edge, the lookup returns the old value. Lookups on later edges return the new value. A host read on that same edge also returns the old value.
- R10: A synchronous reset clears every palette entry to 12'h000 and drives rgb and host_rdata to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_active | input | 1 | Current pixel lies in the visible area |
| bg_valid | input | 1 | Background candidate present |
| bg_pal | input | 3 | Background palette select |
| bg_idx | input | 3 | Background colour index |
| spr_valid | input | NUM_SPR | One valid bit per sprite unit, bit 0 = sprite 0 |
| spr_pal | input | NUM_SPR*3 | Sprite palette selects, sprite n in bits 3n+2:3n |
| spr_idx | input | NUM_SPR*3 | Sprite colour indices, sprite n in bits 3n+2:3n |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host palette address (pal*8 + idx) |
| host_wdata | input | 12 | Host write colour |
| host_rdata | output | 12 | Host read colour, one edge after the address |
| rgb | output | 12 | Output colour {R,G,B} |

## Verification
Two things can happen in the same cycle: a pixel lookup's memory-read edge and a host write to the same palette entry. The bench provokes this by holding a background candidate fixed on one entry and pulsing a write to that entry. It also runs a long stretch of random writes whose addresses are biased toward the entry the current lookup reads. Each collision is judged against a behavioural model that reads the old value before it applies the write, comparing rgb and host_rdata on every clock. The bench then confirms that later pixels show the new colour.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  localparam int LC_NUM_SPR = 8;
  localparam int LC_PAL_W   = 3;
  localparam int LC_IDX_W   = 3;
  localparam int LC_RGB_W   = 12;
endpackage

// File: rtl/lc_prio_select.sv
`timescale 1ns/1ps
module lc_prio_select import lc_pkg::*; #(
  parameter int NUM_SPR = LC_NUM_SPR,
  parameter int PAL_W   = LC_PAL_W,
  parameter int IDX_W   = LC_IDX_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bg_valid,
  input  logic [PAL_W-1:0]           bg_pal,
  input  logic [IDX_W-1:0]           bg_idx,
  input  logic [NUM_SPR-1:0]         spr_valid,
  input  logic [NUM_SPR*PAL_W-1:0]   spr_pal,
  input  logic [NUM_SPR*IDX_W-1:0]   spr_idx,
  output logic                       sel_hit,
  output logic [PAL_W+IDX_W-1:0]     sel_addr
);
  localparam int NUM_W = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1;

  logic [NUM_SPR-1:0] opaque;
  logic               sel_spr;
  logic [NUM_W-1:0]   sel_num;

  // A sprite pixel is opaque when present and not colour index zero.
  for (genvar g = 0; g < NUM_SPR; g++) begin : g_opaque
    assign opaque[g] = spr_valid[g] && (spr_idx[g*IDX_W +: IDX_W] != '0);
  end

  // Background is the fallback; scanning downward leaves the lowest sprite.
  always_comb begin
    sel_hit  = bg_valid;
    sel_spr  = 1'b0;
    sel_num  = '0;
    sel_addr = {bg_pal, bg_idx};
    for (int i = NUM_SPR - 1; i >= 0; i--) begin
      if (opaque[i]) begin
        sel_hit  = 1'b1;
        sel_spr  = 1'b1;
        sel_num  = NUM_W'(i);
        sel_addr = {spr_pal[i*PAL_W +: PAL_W], spr_idx[i*IDX_W +: IDX_W]};
      end
    end
  end

  // R3: a chosen sprite is valid and not transparent
  a_r3_no_clear_winner: assert property (@(posedge clk) disable iff (rst)
    sel_spr |-> (spr_valid[sel_num] && spr_idx[sel_num*IDX_W +: IDX_W] != '0));

  // R5: with no sprite present a valid background is picked
  a_r5_bg_fallback: assert property (@(posedge clk) disable iff (rst)
    (spr_valid == '0 && bg_valid) |-> (sel_hit && !sel_spr));

  for (genvar g = 0; g < NUM_SPR; g++) begin : g_prio_chk
    // R4: no opaque sprite below the chosen number
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
      (sel_spr && int'(sel_num) > g) |->
        !(spr_valid[g] && spr_idx[g*IDX_W +: IDX_W] != '0));
  end
endmodule

// File: rtl/lc_palette_ram.sv
`timescale 1ns/1ps
module lc_palette_ram import lc_pkg::*; #(
  parameter int AW = LC_PAL_W + LC_IDX_W,
  parameter int DW = LC_RGB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_en,
  input  logic [AW-1:0] lk_addr,
  output logic [DW-1:0] lk_data,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write on both ports; blank lookups return zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      lk_data    <= '0;
      host_rdata <= '0;
    end else begin
      lk_data    <= lk_en ? mem[lk_addr] : '0;
      host_rdata <= mem[host_addr];
      if (host_we) mem[host_addr] <= host_wdata;
    end
  end

  // R2: a host write is stored at its address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    host_we |=> mem[$past(host_addr)] == $past(host_wdata));
endmodule

// File: rtl/layer_compositor.sv
`timescale 1ns/1ps
module layer_compositor import lc_pkg::*; #(
  parameter int NUM_SPR = LC_NUM_SPR,
  parameter int PAL_W   = LC_PAL_W,
  parameter int IDX_W   = LC_IDX_W,
  parameter int RGB_W   = LC_RGB_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_active,
  input  logic                       bg_valid,
  input  logic [PAL_W-1:0]           bg_pal,
  input  logic [IDX_W-1:0]           bg_idx,
  input  logic [NUM_SPR-1:0]         spr_valid,
  input  logic [NUM_SPR*PAL_W-1:0]   spr_pal,
  input  logic [NUM_SPR*IDX_W-1:0]   spr_idx,
  input  logic                       host_we,
  input  logic [PAL_W+IDX_W-1:0]     host_addr,
  input  logic [RGB_W-1:0]           host_wdata,
  output logic [RGB_W-1:0]           host_rdata,
  output logic [RGB_W-1:0]           rgb
);
  localparam int AW = PAL_W + IDX_W;

  logic          sel_hit;
  logic [AW-1:0] sel_addr;
  logic          en_q;
  logic [AW-1:0] addr_q;

  lc_prio_select #(.NUM_SPR(NUM_SPR), .PAL_W(PAL_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .bg_valid(bg_valid), .bg_pal(bg_pal), .bg_idx(bg_idx),
    .spr_valid(spr_valid), .spr_pal(spr_pal), .spr_idx(spr_idx),
    .sel_hit(sel_hit), .sel_addr(sel_addr)
  );

  // Address-set stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= pix_active && sel_hit;
      addr_q <= sel_addr;
    end
  end

  // Memory-read stage; its output register drives rgb directly.
  lc_palette_ram #(.AW(AW), .DW(RGB_W)) u_pal (
    .clk(clk), .rst(rst),
    .lk_en(en_q), .lk_addr(addr_q), .lk_data(rgb),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // R7: blanked pixels come out black two edges later
  a_r7_blank_black: assert property (@(posedge clk) disable iff (rst)
    $past(!pix_active, 2) |-> rgb == '0);

  // R10: outputs are zero right after reset
  a_r10_reset_zero: assert property (@(posedge clk)
    $fell(rst) |-> (rgb == '0 && host_rdata == '0));
endmodule

// File: tb/tb_layer_compositor.sv
`timescale 1ns/1ps
module tb_layer_compositor;
  localparam int NS  = 8;
  localparam int PW  = 3;
  localparam int IW  = 3;
  localparam int CW  = 12;
  localparam int AW  = PW + IW;
  localparam int DEP = 1 << AW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pix_active = 1'b0;
  logic           bg_valid = 1'b0;
  logic [PW-1:0]  bg_pal = '0;
  logic [IW-1:0]  bg_idx = '0;
  logic [NS-1:0]  spr_valid = '0;
  logic [NS*PW-1:0] spr_pal = '0;
  logic [NS*IW-1:0] spr_idx = '0;
  logic           host_we = 1'b0;
  logic [AW-1:0]  host_addr = '0;
  logic [CW-1:0]  host_wdata = '0;
  logic [CW-1:0]  host_rdata;
  logic [CW-1:0]  rgb;

  layer_compositor #(.NUM_SPR(NS), .PAL_W(PW), .IDX_W(IW), .RGB_W(CW)) dut (
    .clk(clk), .rst(rst), .pix_active(pix_active),
    .bg_valid(bg_valid), .bg_pal(bg_pal), .bg_idx(bg_idx),
    .spr_valid(spr_valid), .spr_pal(spr_pal), .spr_idx(spr_idx),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rgb(rgb)
  );

  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_err = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R10";

  // Behavioural model.
  logic [CW-1:0] mmem [DEP];
  bit            m_en = 0;
  logic [AW-1:0] m_addr = '0;
  logic [CW-1:0] e_rgb = '0;
  logic [CW-1:0] e_rd = '0;

  always @(posedge clk) begin
    int w;
    logic [CW-1:0] n_rgb, n_rd;
    if (rst) begin
      for (int a = 0; a < DEP; a++) mmem[a] = '0;
      m_en = 0; m_addr = '0; e_rgb = '0; e_rd = '0;
    end else begin
      n_rgb = m_en ? mmem[m_addr] : '0;
      n_rd  = mmem[host_addr];
      w = -1;
      for (int i = 0; i < NS; i++)
        if (w < 0 && spr_valid[i] && spr_idx[i*IW +: IW] != 0) w = i;
      if (w >= 0) begin
        m_en = pix_active;
        m_addr = AW'(spr_pal[w*PW +: PW] * 8 + spr_idx[w*IW +: IW]);
      end else if (bg_valid) begin
        m_en = pix_active;
        m_addr = AW'(bg_pal * 8 + bg_idx);
      end else begin
        m_en = 0;
      end
      if (host_we) mmem[host_addr] = host_wdata;
      e_rgb = n_rgb;
      e_rd  = n_rd;
    end
    started = 1;
  end

  task automatic check(input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("rgb", rgb, e_rgb);
      check("host_rdata", host_rdata, e_rd);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_spr();
    spr_valid = '0; spr_pal = '0; spr_idx = '0;
  endtask

  task automatic rand_pixel(input int zero_bias);
    for (int i = 0; i < NS; i++) begin
      spr_valid[i] = 1'($urandom % 2);
      spr_pal[i*PW +: PW] = PW'($urandom);
      spr_idx[i*IW +: IW] = (($urandom % 4) < zero_bias) ? '0 : IW'($urandom);
    end
    bg_valid = 1'($urandom % 4 != 0);
    bg_pal = PW'($urandom);
    bg_idx = IW'($urandom);
  endtask

  function automatic logic [CW-1:0] colour_of(input int a);
    return CW'((a * 12'h2B5) ^ 12'h5A3) | 12'h001;
  endfunction

  initial begin
    repeat (3) step();
    rst = 1'b0;

    // R10: after reset all entries read zero, rgb zero
    cur_req = "R10";
    pix_active = 1'b1; bg_valid = 1'b1;
    for (int a = 0; a < DEP; a++) begin host_addr = AW'(a); step(); end

    // R2: fill the palette, then read every entry back
    cur_req = "R2";
    bg_valid = 1'b0;
    for (int a = 0; a < DEP; a++) begin
      host_we = 1'b1; host_addr = AW'(a); host_wdata = colour_of(a); step();
    end
    host_we = 1'b0;
    for (int a = 0; a < DEP; a++) begin host_addr = AW'(DEP - 1 - a); step(); end

    // R1: background walks every palette/index pair
    cur_req = "R1";
    bg_valid = 1'b1;
    for (int a = 0; a < DEP; a++) begin
      bg_pal = PW'(a / 8); bg_idx = IW'(a % 8); step();
    end

    // R5: sprites present but see-through or invalid; background index 0 shown
    cur_req = "R5";
    for (int n = 0; n < 40; n++) begin
      bg_pal = PW'(n); bg_idx = (n % 3 == 0) ? '0 : IW'(n * 5);
      for (int i = 0; i < NS; i++) begin
        spr_pal[i*PW +: PW] = PW'(i + n);
        spr_valid[i] = (i % 2 == 0);
        spr_idx[i*IW +: IW] = (i % 2 == 0) ? '0 : IW'(i + 1);
      end
      step();
    end

    // R3: mostly-transparent random sprites
    cur_req = "R3";
    for (int n = 0; n < 200; n++) begin rand_pixel(3); step(); end

    // R4: several opaque sprites compete
    cur_req = "R4";
    for (int n = 0; n < 200; n++) begin rand_pixel(1); step(); end
    for (int k = NS - 1; k >= 0; k--) begin
      for (int i = 0; i < NS; i++) begin
        spr_valid[i] = (i >= k);
        spr_pal[i*PW +: PW] = PW'(i);
        spr_idx[i*IW +: IW] = IW'(7 - (i % 7));
      end
      step();
    end

    // R6: nothing to show
    cur_req = "R6";
    bg_valid = 1'b0;
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < NS; i++) begin
        spr_valid[i] = 1'($urandom % 2);
        spr_idx[i*IW +: IW] = spr_valid[i] ? '0 : IW'(n + 1);
      end
      step();
    end

    // R7: blanking interleaved with content
    cur_req = "R7";
    for (int n = 0; n < 120; n++) begin
      rand_pixel(1);
      pix_active = (n % 5 > 1);
      step();
    end
    pix_active = 1'b1;

    // R8: isolated single-pixel pulses
    cur_req = "R8";
    for (int n = 0; n < 8; n++) begin
      clear_spr(); bg_valid = 1'b0; step();
      spr_valid[n] = 1'b1; spr_pal[n*PW +: PW] = PW'(n); spr_idx[n*IW +: IW] = IW'(n + 1);
      step();
      clear_spr(); step(); step();
    end

    // R9: host write hits the entry being looked up
    cur_req = "R9";
    clear_spr(); bg_valid = 1'b1; bg_pal = 3'd5; bg_idx = 3'd2;
    host_addr = 6'd42; step(); step();
    host_we = 1'b1; host_wdata = 12'hABC; step();
    host_we = 1'b0; step(); step(); step();
    for (int n = 0; n < 200; n++) begin
      rand_pixel(2);
      host_we = 1'($urandom % 2);
      host_addr = ($urandom % 2) ? AW'(bg_pal * 8 + bg_idx) : AW'($urandom);
      host_wdata = CW'($urandom);
      step();
    end
    host_we = 1'b0;

    // R10: reset mid-run clears the palette again
    cur_req = "R10";
    rst = 1'b1; step(); step();
    rst = 1'b0;
    for (int a = 0; a < DEP; a++) begin
      host_addr = AW'(a); bg_pal = PW'(a / 8); bg_idx = IW'(a % 8); step();
    end
    step(); step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule